// File: doc/BRIEF.md
# Four-Mode Timer/Counter

This block is a single timer/counter held in two count bytes, a low byte and a high byte, plus a 4-bit mode register and a small control register. It advances once for each machine-cycle strobe (timer use), or once for each falling edge seen on an external count pin (counter use). The low side can be gated by the level of an external interrupt pin.

A 2-bit mode field arranges the two bytes in one of four ways:
- a 13-bit count (high byte over a 5-bit prescale in the low byte),
- a full 16-bit count,
- an 8-bit low byte that reloads itself from the high byte,
- two independent 8-bit counters.

In the split arrangement the high byte has its own run bit and its own overflow flag, so it behaves as a second 8-bit timer with its own interrupt. Software loads every register through a single write port. The interrupt vectoring logic clears each overflow flag with an acknowledge pulse.

Top module: `tmr_unit`

## Requirements
- R1: After reset both count bytes, the mode register, both run bits and both overflow flags read zero.
- R2: In timer use (mode bit 2 = 0) the low side advances by one at each clock edge where `mcTick` is high and counting is enabled. With `mcTick` low, no count changes.
- R3: The low side counts only while run bit A is 1 and either the gate enable (mode bit 3) is 0 or `gatePin` is high.
- R4: In counter use (mode bit 2 = 1), `extPin` is sampled only when `mcTick` is high. A count of one is made when the previous sample was 1 and the current sample is 0. A steady level makes no count. The sample history is 0 after reset.
- R5: Mode field (bits 1:0) 00 forms a 13-bit count from the high byte and low-byte bits 4:0. Low-byte bits 7:5 are never changed by counting. The wrap from 0x1FFF to zero sets flag A.
- R6: Mode 01 forms a 16-bit count with the high byte on top. The wrap from 0xFFFF to zero sets flag A at the same edge that the count becomes zero.
- R7: In mode 10, a low-byte step from 0xFF loads the high byte into the low byte and sets flag A. The high byte is never changed by counting.
- R8: In mode 11, the low byte counts alone and uses run bit A, the gate, the timer/counter select and flag A. The high byte counts `mcTick` strobes while run bit B is 1, and sets flag B when it wraps from 0xFF.
- R9: Writing the control register (setting a run bit) leaves both count bytes unchanged.
- R10: `ackA`/`ackB` clear flag A/flag B. A control write loads both flags. A hardware overflow in the same cycle as an acknowledge or a write wins, and the flag is set.
- R11: The write port selects with `wrSel`: 0 = low byte, 1 = high byte, 2 = mode, 3 = control. Control bits are 0 = run A, 1 = run B, 2 = flag A, 3 = flag B. When a count byte is written in a cycle where a count step would read or change it, the byte takes the written value and that step, with its flag, is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mcTick | input | 1 | Machine-cycle strobe, one clock wide |
| extPin | input | 1 | External count pin |
| gatePin | input | 1 | External gate level (interrupt pin) |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Write target select |
| wrData | input | 8 | Write data |
| ackA | input | 1 | Vectoring acknowledge, clears flag A |
| ackB | input | 1 | Vectoring acknowledge, clears flag B |
| lowByte | output | 8 | Low count byte |
| highByte | output | 8 | High count byte |
| modeReg | output | 4 | Mode register: gate, counter select, mode field |
| runA | output | 1 | Run bit for the low side |
| runB | output | 1 | Run bit for the split high byte |
| flagA | output | 1 | Overflow flag of the main count |
| flagB | output | 1 | Overflow flag of the split high byte |

## Verification
Every result here appears after exactly one clock edge. A strobe, pin sample, write or acknowledge that is driven before a rising edge shows on the outputs right after that edge. This holds both for count steps and for a flag rising together with a wrap to zero. The bench drives all inputs on the falling edge and reads the outputs on the next falling edge, so each check lands one edge after its stimulus. The bench also leaves idle clocks without `mcTick`, and confirms that the counts stay still across them. Same-edge collisions (a write against a step, an acknowledge against a wrap) are driven in one cycle, so the outcome of the priority rule is observed directly.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_LOW  = 2'd0,
    SEL_HIGH = 2'd1,
    SEL_MODE = 2'd2,
    SEL_CTRL = 2'd3
  } selT;

  typedef enum logic [1:0] {
    MODE_13     = 2'd0,
    MODE_16     = 2'd1,
    MODE_RELOAD = 2'd2,
    MODE_SPLIT  = 2'd3
  } modeT;

  // strobes from control to datapath, valid for one clock
  typedef struct packed {
    logic incLow;
    logic incHigh;
    logic wrLow;
    logic wrHigh;
    logic wrFlags;
    logic flagAData;
    logic flagBData;
    logic ackA;
    logic ackB;
  } stepT;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       mcTick,
  input  logic       extPin,
  input  logic       gatePin,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic [3:0] cfgData,
  input  logic       ackA,
  input  logic       ackB,
  output modeT       modeSel,
  output logic [3:0] modeBits,
  output logic       runAQ,
  output logic       runBQ,
  output stepT       step
);
  logic [3:0] modeQ;
  logic       prevSample;
  logic       fallSeen;
  logic       enableA;
  logic       lowEvent;
  logic       wrLowHit;
  logic       wrHighHit;
  logic       cntSel;
  logic       gateOn;
  selT        sel;

  assign sel      = selT'(wrSel);
  assign modeSel  = modeT'(modeQ[1:0]);
  assign cntSel   = modeQ[2];
  assign gateOn   = modeQ[3];
  assign modeBits = modeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ      <= '0;
      runAQ      <= 1'b0;
      runBQ      <= 1'b0;
      prevSample <= 1'b0;
    end else begin
      if (wrEn && sel == SEL_MODE) modeQ <= cfgData;
      if (wrEn && sel == SEL_CTRL) begin
        runAQ <= cfgData[0];
        runBQ <= cfgData[1];
      end
      if (mcTick) prevSample <= extPin;
    end
  end

  assign fallSeen  = prevSample & ~extPin;
  assign enableA   = runAQ & (~gateOn | gatePin);
  assign lowEvent  = cntSel ? fallSeen : 1'b1;
  assign wrLowHit  = wrEn && sel == SEL_LOW;
  assign wrHighHit = wrEn && sel == SEL_HIGH;

  always_comb begin
    step           = '0;
    step.wrLow     = wrLowHit;
    step.wrHigh    = wrHighHit;
    step.wrFlags   = wrEn && sel == SEL_CTRL;
    step.flagAData = cfgData[2];
    step.flagBData = cfgData[3];
    step.ackA      = ackA;
    step.ackB      = ackB;
    if (modeSel == MODE_SPLIT) begin
      step.incLow  = mcTick & enableA & lowEvent & ~wrLowHit;
      step.incHigh = mcTick & runBQ & ~wrHighHit;
    end else begin
      step.incLow  = mcTick & enableA & lowEvent & ~wrLowHit & ~wrHighHit;
      step.incHigh = 1'b0;
    end
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  modeT              modeSel,
  input  stepT              step,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] lowQ,
  output logic [BYTE_W-1:0] highQ,
  output logic              flagAQ,
  output logic              flagBQ
);
  localparam int WIDE_W = 2 * BYTE_W;

  logic [BYTE_W-1:0] lowN;
  logic [BYTE_W-1:0] highN;
  logic [PRE_W-1:0]  preN;
  logic [WIDE_W-1:0] wideN;
  logic              ovfA;
  logic              ovfB;
  logic              flagAN;
  logic              flagBN;

  always_comb begin
    lowN  = lowQ;
    highN = highQ;
    preN  = lowQ[PRE_W-1:0];
    wideN = {highQ, lowQ};
    ovfA  = 1'b0;
    ovfB  = 1'b0;
    unique case (modeSel)
      MODE_13: if (step.incLow) begin
        preN = lowQ[PRE_W-1:0] + 1'b1;
        lowN[PRE_W-1:0] = preN;
        if (&lowQ[PRE_W-1:0]) begin
          highN = highQ + 1'b1;
          ovfA  = &highQ;
        end
      end
      MODE_16: if (step.incLow) begin
        wideN = {highQ, lowQ} + 1'b1;
        {highN, lowN} = wideN;
        ovfA = &{highQ, lowQ};
      end
      MODE_RELOAD: if (step.incLow) begin
        if (&lowQ) begin
          lowN = highQ;
          ovfA = 1'b1;
        end else begin
          lowN = lowQ + 1'b1;
        end
      end
      MODE_SPLIT: begin
        if (step.incLow) begin
          lowN = lowQ + 1'b1;
          ovfA = &lowQ;
        end
        if (step.incHigh) begin
          highN = highQ + 1'b1;
          ovfB  = &highQ;
        end
      end
      default: ;
    endcase
    if (step.wrLow)  lowN  = wrData;
    if (step.wrHigh) highN = wrData;
    flagAN = ((step.wrFlags ? step.flagAData : flagAQ) & ~step.ackA) | ovfA;
    flagBN = ((step.wrFlags ? step.flagBData : flagBQ) & ~step.ackB) | ovfB;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowQ   <= '0;
      highQ  <= '0;
      flagAQ <= 1'b0;
      flagBQ <= 1'b0;
    end else begin
      lowQ   <= lowN;
      highQ  <= highN;
      flagAQ <= flagAN;
      flagBQ <= flagBN;
    end
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
  import tmr_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int PRE_W  = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mcTick,
  input  logic              extPin,
  input  logic              gatePin,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              ackA,
  input  logic              ackB,
  output logic [BYTE_W-1:0] lowByte,
  output logic [BYTE_W-1:0] highByte,
  output logic [3:0]        modeReg,
  output logic              runA,
  output logic              runB,
  output logic              flagA,
  output logic              flagB
);
  modeT modeSel;
  stepT step;

  tmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .mcTick(mcTick), .extPin(extPin), .gatePin(gatePin),
    .wrEn(wrEn), .wrSel(wrSel), .cfgData(wrData[3:0]), .ackA(ackA), .ackB(ackB),
    .modeSel(modeSel), .modeBits(modeReg), .runAQ(runA), .runBQ(runB), .step(step)
  );

  tmr_datapath #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .step(step), .wrData(wrData),
    .lowQ(lowByte), .highQ(highByte), .flagAQ(flagA), .flagBQ(flagB)
  );
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              mcTick,
  input logic              wrEn,
  input logic [1:0]        wrSel,
  input logic              ackB,
  input logic [BYTE_W-1:0] lowByte,
  input logic [BYTE_W-1:0] highByte,
  input logic [3:0]        modeReg,
  input logic              runA,
  input logic              runB,
  input logic              flagA,
  input logic              flagB
);
  // R2: no strobe and no write, counts hold
  p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!mcTick && !wrEn) |=> ($stable(lowByte) && $stable(highByte)));

  // R2: timer step of one in the 16-bit arrangement
  p_step_one_r2: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg == 4'b0001 && mcTick && runA && !wrEn)
    |=> ({highByte, lowByte} == $past({highByte, lowByte}) + 1'b1));

  // R3: both run bits off, counts hold
  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!runA && !runB && !wrEn) |=> ($stable(lowByte) && $stable(highByte)));

  // R5: upper prescale bits untouched by counting
  p_top_bits_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[1:0] == 2'b00 && !(wrEn && wrSel == 2'd0))
    |=> $stable(lowByte[7:5]));

  // R6: flag rises together with the wrap to zero
  p_wrap_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[1:0] == 2'b01 && $rose(flagA) && !$past(wrEn))
    |-> (lowByte == '0 && highByte == '0));

  // R7: reload arrangement never changes the high byte by counting
  p_reload_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[1:0] == 2'b10 && !(wrEn && wrSel == 2'd1)) |=> $stable(highByte));

  // R10: outside the split arrangement an acknowledge always clears flag B
  p_ack_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ackB && modeReg[1:0] != 2'b11 && !(wrEn && wrSel == 2'd3)) |=> !flagB);
endmodule

bind tmr_unit tmr_unit_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .mcTick(mcTick), .wrEn(wrEn), .wrSel(wrSel), .ackB(ackB),
  .lowByte(lowByte), .highByte(highByte), .modeReg(modeReg), .runA(runA),
  .runB(runB), .flagA(flagA), .flagB(flagB)
);

// File: tb/sim_tmr_unit.sv
module sim_tmr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mcTick = 1'b0, extPin = 1'b0, gatePin = 1'b0, wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [7:0] wrData = '0;
  logic ackA = 1'b0, ackB = 1'b0;
  logic [7:0] lowByte, highByte;
  logic [3:0] modeReg;
  logic runA, runB, flagA, flagB;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tmr_unit u0 (
    .clk(clk), .rstN(rstN), .mcTick(mcTick), .extPin(extPin), .gatePin(gatePin),
    .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData), .ackA(ackA), .ackB(ackB),
    .lowByte(lowByte), .highByte(highByte), .modeReg(modeReg), .runA(runA),
    .runB(runB), .flagA(flagA), .flagB(flagB)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      mcTick = 1'b1;
      @(negedge clk);
      mcTick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 low", lowByte, 0);
    check("R1 high", highByte, 0);
    check("R1 mode", modeReg, 0);
    check("R1 runs", {runA, runB}, 0);
    check("R1 flags", {flagA, flagB}, 0);
  endtask

  task automatic t_timer();
    wr(2'd2, 8'h01);
    wr(2'd3, 8'h01);
    ticks(5);
    check("R2 five steps", {highByte, lowByte}, 5);
    idle(6);
    check("R2 idle no change", {highByte, lowByte}, 5);
    wr(2'd3, 8'h00);
    ticks(3);
    check("R2 stopped", {highByte, lowByte}, 5);
    wr(2'd3, 8'h01);
    check("R9 run set keeps count", {highByte, lowByte}, 5);
  endtask

  task automatic t_gate();
    wr(2'd2, 8'h09);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    gatePin = 1'b0;
    ticks(3);
    check("R3 gated low", lowByte, 0);
    gatePin = 1'b1;
    ticks(3);
    check("R3 gate high", lowByte, 3);
  endtask

  task automatic t_counter();
    wr(2'd2, 8'h05);
    wr(2'd0, 8'h00);
    extPin = 1'b1; ticks(1);
    check("R4 rise no count", lowByte, 0);
    extPin = 1'b0; ticks(1);
    check("R4 fall counts", lowByte, 1);
    ticks(2);
    check("R4 steady low", lowByte, 1);
    extPin = 1'b1; idle(3); extPin = 1'b0;
    ticks(1);
    check("R4 unsampled pulse", lowByte, 1);
    extPin = 1'b1; ticks(1); extPin = 1'b0; ticks(1);
    check("R4 second fall", lowByte, 2);
  endtask

  task automatic t_mode0();
    gatePin = 1'b0;
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h01);
    wr(2'd1, 8'hFF); wr(2'd0, 8'hFE);
    ticks(1);
    check("R5 prescale step", lowByte, 8'hFF);
    check("R5 no early flag", flagA, 0);
    ticks(1);
    check("R5 wrap low keeps top", lowByte, 8'hE0);
    check("R5 wrap high", highByte, 0);
    check("R5 flag", flagA, 1);
    wr(2'd3, 8'h01);
    wr(2'd1, 8'h10); wr(2'd0, 8'h1F);
    ticks(1);
    check("R5 carry high", highByte, 8'h11);
    check("R5 carry low", lowByte, 0);
  endtask

  task automatic t_mode1();
    wr(2'd2, 8'h01);
    wr(2'd1, 8'hFF); wr(2'd0, 8'hFF);
    ticks(1);
    check("R6 wrap to zero", {highByte, lowByte}, 0);
    check("R6 flag", flagA, 1);
  endtask

  task automatic t_ack();
    @(negedge clk); ackA = 1'b1;
    @(negedge clk); ackA = 1'b0;
    check("R10 ack clears", flagA, 0);
    wr(2'd3, 8'h0D);
    check("R10 write flags", {flagB, flagA, runA}, 3'b111);
    wr(2'd3, 8'h01);
    check("R10 write clears", {flagB, flagA}, 0);
    wr(2'd1, 8'hFF); wr(2'd0, 8'hFF);
    @(negedge clk); mcTick = 1'b1; ackA = 1'b1;
    @(negedge clk); mcTick = 1'b0; ackA = 1'b0;
    check("R10 set beats ack", flagA, 1);
    wr(2'd3, 8'h01);
  endtask

  task automatic t_mode2();
    wr(2'd2, 8'h02);
    wr(2'd1, 8'h80); wr(2'd0, 8'hFE);
    ticks(1);
    check("R7 step", lowByte, 8'hFF);
    ticks(1);
    check("R7 reload", lowByte, 8'h80);
    check("R7 high kept", highByte, 8'h80);
    check("R7 flag", flagA, 1);
    wr(2'd3, 8'h01);
  endtask

  task automatic t_mode3();
    wr(2'd2, 8'h03);
    wr(2'd3, 8'h02);
    wr(2'd0, 8'h00); wr(2'd1, 8'hFE);
    ticks(2);
    check("R8 high wraps", highByte, 0);
    check("R8 flagB", flagB, 1);
    check("R8 low idle", lowByte, 0);
    check("R8 flagA clear", flagA, 0);
    @(negedge clk); ackB = 1'b1;
    @(negedge clk); ackB = 1'b0;
    check("R10 ackB", flagB, 0);
    wr(2'd3, 8'h01);
    ticks(2);
    check("R8 low counts", lowByte, 2);
    check("R8 high stopped", highByte, 0);
  endtask

  task automatic t_priority();
    wr(2'd2, 8'h01);
    wr(2'd0, 8'h05); wr(2'd1, 8'h22);
    @(negedge clk); mcTick = 1'b1; wrEn = 1'b1; wrSel = 2'd0; wrData = 8'h40;
    @(negedge clk); mcTick = 1'b0; wrEn = 1'b0;
    check("R11 write wins low", lowByte, 8'h40);
    check("R11 high untouched", highByte, 8'h22);
    wr(2'd1, 8'hFF); wr(2'd0, 8'hFF);
    @(negedge clk); mcTick = 1'b1; wrEn = 1'b1; wrSel = 2'd1; wrData = 8'h12;
    @(negedge clk); mcTick = 1'b0; wrEn = 1'b0;
    check("R11 high written", highByte, 8'h12);
    check("R11 step dropped", lowByte, 8'hFF);
    check("R11 no flag", flagA, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    t_reset();
    t_timer();
    t_gate();
    t_counter();
    t_mode0();
    t_mode1();
    t_ack();
    t_mode2();
    t_mode3();
    t_priority();
    finish_run();
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end
endmodule